// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

When a transfer on an I2C bus is cut short, a slave may be left part-way through a byte and keep SDA pulled low. While SDA stays low, no master can create a START. This block frees the bus by clocking the stuck slave until it lets go of SDA. It then puts a clean STOP condition on the wire.

A recovery attempt begins in one of two ways: software sends a one-cycle request, or the master's error signal fires. The block first looks at the synchronized SDA level. If SDA is already high, nothing is driven and the attempt finishes at once. If SDA is low, the block forces SCL low for one half-period and then releases it for one half-period. At the end of each released half it looks at SDA again. Pulsing stops when SDA reads high, or when a pulse limit is reached.

After pulsing, the block forms a STOP. It holds both lines low, then releases SCL while keeping SDA low, then releases SDA. The half-period is a tick count on an input, so the same netlist works at any system clock rate. The outputs are open-drain style override enables: 1 pulls the line low.

Top module: `i2c_unstick_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it, every output (`scl_low_o`, `sda_low_o`, `busy_o`, `done_o`, `fail_o`) is 0.
- R2: When idle, a cycle with `start_i` or `err_i` high accepts a recovery. If the synchronized SDA is high at that edge, `done_o` is 1 in the next cycle, and neither override is ever asserted.
- R3: If SDA is low on acceptance, pulsing starts in the next cycle. Each pulse is H cycles of `scl_low_o`=1 followed by H cycles of `scl_low_o`=0, where H = `half_period_i`. A value of 0 is treated as 1.
- R4: SDA passes through a SYNC_STAGES-flop synchronizer and is judged in the last cycle of each released half. A high level ends pulsing after that pulse.
- R5: At most MAX_PULSES pulses are issued (default 10). If SDA is still low after the last one, `fail_o` becomes 1 together with `done_o`.
- R6: After pulsing, the STOP is formed in three steps. First, `scl_low_o` and `sda_low_o` are both 1 for H cycles. Next, only `sda_low_o` is 1 for H cycles. Then both are 0 and `done_o` is 1.
- R7: `busy_o` is 1 from the first pulse cycle through the last STOP cycle. `start_i` and `err_i` are ignored while busy, and no request is queued.
- R8: `done_o` is a single-cycle pulse with `busy_o`=0. `fail_o` holds its value from that cycle until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Software recovery request, one cycle |
| err_i | input | 1 | Master error indication, triggers recovery |
| sda_i | input | 1 | Sensed SDA line level, asynchronous |
| half_period_i | input | TW | Half-period in clock cycles (0 acts as 1) |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |
| busy_o | output | 1 | Recovery sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | SDA never released within the pulse limit |

## Verification
A wrong state, a miscounted phase or a wrong pulse count changes the SCL and SDA override waveform within one half-period. The bench compares that waveform, cycle by cycle, with a trace built from the requirements. A slave model releases SDA after a chosen number of clock pulses, which places the release before, at and after the pulse limit. A request that leaked through while busy would show as a restarted waveform or as `busy_o` rising after `done_o`; both are checked in the quiet cycles that follow each sequence.

// File: rtl/uss_pkg.sv
package uss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCL_LO,
    ST_SCL_HI,
    ST_STOP_BOTH,
    ST_STOP_SDA,
    ST_FIN
  } uss_state_e;
endpackage

// File: rtl/uss_sync.sv
module uss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_flops
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2+((STAGES==1)?1:0):0], d_i};
      end
      assign q_o = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/uss_phase_timer.sv
module uss_phase_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] half_i,
  output logic          last_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                   cnt_q <= '0;
    else if (load_i)           cnt_q <= (half_i == '0) ? '0 : half_i - TW'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - TW'(1);
  end

  assign last_o = (cnt_q == '0);

  // R3: a freshly loaded phase never exceeds the programmed half-period
  p_load_bound_r3: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q < $past(half_i)) || ($past(half_i) == '0));
endmodule

// File: rtl/uss_pulse_ctr.sv
module uss_pulse_ctr #(
  parameter int MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int CW = $clog2(MAX_PULSES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CW'(1);
  end

  assign at_limit_o = (cnt_q == CW'(MAX_PULSES));

  p_pulse_cap_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAX_PULSES));
  p_no_inc_at_cap_r5: assert property (@(posedge clk) disable iff (rst)
    (at_limit_o && !clr_i) |-> !inc_i);
endmodule

// File: rtl/uss_fsm.sv
module uss_fsm
  import uss_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic err_i,
  input  logic sda_s_i,
  input  logic phase_end_i,
  input  logic at_limit_i,
  output logic tmr_load_o,
  output logic cnt_clr_o,
  output logic cnt_inc_o,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  uss_state_e st_q, st_d;
  logic stuck_q, stuck_d;
  logic accept;

  assign accept = (st_q == ST_IDLE) && (start_i || err_i);

  always_comb begin
    st_d      = st_q;
    stuck_d   = stuck_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cnt_clr_o = 1'b1;
          stuck_d   = 1'b0;
          st_d      = sda_s_i ? ST_FIN : ST_SCL_LO;
        end
      end
      ST_SCL_LO: begin
        if (phase_end_i) begin
          cnt_inc_o = 1'b1;
          st_d      = ST_SCL_HI;
        end
      end
      ST_SCL_HI: begin
        if (phase_end_i) begin
          if (sda_s_i) begin
            st_d = ST_STOP_BOTH;
          end else if (at_limit_i) begin
            stuck_d = 1'b1;
            st_d    = ST_STOP_BOTH;
          end else begin
            st_d = ST_SCL_LO;
          end
        end
      end
      ST_STOP_BOTH: if (phase_end_i) st_d = ST_STOP_SDA;
      ST_STOP_SDA:  if (phase_end_i) st_d = ST_FIN;
      ST_FIN:       st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  assign tmr_load_o = (st_q == ST_IDLE) || (st_d != st_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      stuck_q   <= 1'b0;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
    end else begin
      st_q      <= st_d;
      stuck_q   <= stuck_d;
      scl_low_o <= (st_d == ST_SCL_LO) || (st_d == ST_STOP_BOTH);
      sda_low_o <= (st_d == ST_STOP_BOTH) || (st_d == ST_STOP_SDA);
      busy_o    <= (st_d == ST_SCL_LO) || (st_d == ST_SCL_HI) ||
                   (st_d == ST_STOP_BOTH) || (st_d == ST_STOP_SDA);
      done_o    <= (st_d == ST_FIN);
      if (accept || st_d == ST_FIN) fail_o <= stuck_d;
    end
  end

  p_scl_needs_busy_r7: assert property (@(posedge clk) disable iff (rst)
    scl_low_o |-> busy_o);
  p_sda_needs_busy_r7: assert property (@(posedge clk) disable iff (rst)
    sda_low_o |-> busy_o);
  p_sda_grab_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low_o) |-> scl_low_o);
  p_sda_release_done_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_low_o) |-> (done_o && !scl_low_o));
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  p_fail_at_done_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> done_o);
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq #(
  parameter int TW          = 16,
  parameter int MAX_PULSES  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          err_i,
  input  logic          sda_i,
  input  logic [TW-1:0] half_period_i,
  output logic          scl_low_o,
  output logic          sda_low_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);
  logic sda_s, phase_end, at_limit, tmr_load, cnt_clr, cnt_inc;

  uss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(sda_i), .q_o(sda_s)
  );

  uss_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load_i(tmr_load), .half_i(half_period_i),
    .last_o(phase_end)
  );

  uss_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .at_limit_o(at_limit)
  );

  uss_fsm u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .err_i(err_i),
    .sda_s_i(sda_s), .phase_end_i(phase_end), .at_limit_i(at_limit),
    .tmr_load_o(tmr_load), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o)
  );
endmodule

// File: tb/test_i2c_unstick_seq.sv
module test_i2c_unstick_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TW   = 16;
  localparam int MAXP = 10;

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, err_i = 1'b0, sda_i = 1'b1;
  logic [TW-1:0] half = 16'd4;
  logic scl_low, sda_low, busy, done, fail;
  int n_tests = 0, n_fail = 0;
  int release_after = 0, fall_cnt = 0;
  logic prev_scl = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_unstick_seq #(.TW(TW), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) i_i2c_unstick_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .err_i(err_i), .sda_i(sda_i),
    .half_period_i(half), .scl_low_o(scl_low), .sda_low_o(sda_low),
    .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  // Stuck slave: holds SDA low until it has seen release_after SCL pulses
  always @(negedge clk) begin
    if (prev_scl && !scl_low) fall_cnt = fall_cnt + 1;
    prev_scl = scl_low;
    sda_i = !((fall_cnt < release_after) || sda_low);
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pulses(int n);
    return (n > MAXP) ? MAXP : n;
  endfunction

  // expected {scl,sda,busy,done} at trace index i
  function automatic logic [3:0] exp_trace(int p, int he, int i);
    int j;
    if (p == 0) return (i == 0) ? 4'b0001 : 4'b0000;
    if (i < 2*he*p) return ((i % (2*he)) < he) ? 4'b1010 : 4'b0010;
    j = i - 2*he*p;
    if (j < he)   return 4'b1110;
    if (j < 2*he) return 4'b0110;
    return 4'b0001;
  endfunction

  // poke: 0 none, 1 start while busy, 2 err while busy
  task automatic run_case(int n, int h, bit use_err, int poke);
    int p, he, len, bad_scl, bad_sda, bad_busy, bad_done, bad_fail;
    logic [3:0] e;
    bit ef;
    @(negedge clk);
    half = TW'(h);
    release_after = n;
    fall_cnt = 0;
    repeat (5) @(negedge clk);
    if (use_err) err_i = 1'b1; else start_i = 1'b1;
    @(negedge clk);
    err_i = 1'b0; start_i = 1'b0;
    p = exp_pulses(n);
    he = (h == 0) ? 1 : h;
    ef = (n > MAXP);
    len = (p == 0) ? 1 : 2*he*p + 2*he + 1;
    bad_scl = 0; bad_sda = 0; bad_busy = 0; bad_done = 0; bad_fail = 0;
    for (int i = 0; i < len; i++) begin
      e = exp_trace(p, he, i);
      if (scl_low != e[3]) bad_scl++;
      if (sda_low != e[2]) bad_sda++;
      if (busy != e[1]) bad_busy++;
      if (done != e[0]) bad_done++;
      if (fail != ((i == len-1) ? ef : 1'b0)) bad_fail++;
      start_i = (poke == 1) && (i == 2);
      err_i   = (poke == 2) && (i == 3);
      @(negedge clk);
    end
    start_i = 1'b0; err_i = 1'b0;
    chk("R3 scl override waveform mismatches", bad_scl, 0);
    chk("R6 sda override waveform mismatches", bad_sda, 0);
    chk("R7 busy waveform mismatches", bad_busy, 0);
    chk("R8 done waveform mismatches", bad_done, 0);
    chk("R5 fail flag mismatches", bad_fail, 0);
    for (int k = 0; k < 4; k++) begin
      chk("R7 no restart after done (busy)", busy, 0);
      chk("R8 fail held after done", fail, ef);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20511));
    repeat (3) @(negedge clk);
    chk("R1 reset scl", scl_low, 0);
    chk("R1 reset sda", sda_low, 0);
    chk("R1 reset busy/done/fail", {busy, done, fail}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset outputs", {scl_low, sda_low, busy, done, fail}, 0);

    run_case(0, 4, 1'b0, 0);      // R2 SDA high, start
    run_case(0, 5, 1'b1, 0);      // R2 SDA high, error trigger
    run_case(1, 3, 1'b0, 0);      // R4 released after first pulse
    run_case(3, 6, 1'b1, 0);      // R4 error-triggered recovery
    run_case(MAXP, 4, 1'b0, 0);   // R5 release exactly at the limit
    run_case(MAXP+1, 4, 1'b0, 0); // R5 one past the limit -> fail
    run_case(99, 0, 1'b0, 0);     // R3 zero half-period acts as one
    run_case(0, 3, 1'b0, 0);      // R8 fail cleared by next request
    run_case(4, 5, 1'b0, 1);      // R7 start ignored while busy
    run_case(2, 3, 1'b1, 2);      // R7 error ignored while busy
    for (int r = 0; r < 20; r++) begin
      run_case($urandom_range(0, 12), $urandom_range(3, 8),
               1'($urandom_range(0, 1)), $urandom_range(0, 2));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule